// File: doc/BRIEF.md
# Single-Wire EEPROM Write-Enable Front End

This block sits behind the bit-level receiver of a single-wire serial EEPROM slave. It takes whole bytes from that receiver. Each byte carries a flag that tells whether the master acknowledged it (`byteMak` = 1) or declined to (`byteMak` = 0). The block also takes a one-cycle pulse that marks the standby gap in front of every transaction. It checks the start header and the device address, then decodes the two commands that govern writing: enable and disable. It also keeps the write-enable latch that the write logic consults before it lets any array or status update finish.

A command takes effect only when the master closes it with a not-acknowledge. It then produces a one-cycle request for the bit-level side to send a slave acknowledge. Any command byte other than the two it owns goes to the downstream instruction decoder on a one-cycle strobe. Completion strobes from the write, status-write, erase-all and set-all engines clear the latch, because every such operation uses up the enable.

Top module: `swire_wel_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `welOut`, `sakReq` and `cmdValid` are all 0.
- R2: After a `standbyIn` pulse, the next valid byte must be 0x55. Any other value sends the block idle, and it ignores every byte until the next `standbyIn` pulse.
- R3: The byte after the header must equal 0xA0 when `altAddrSel` is 0, or 0xA1 when `altAddrSel` is 1. A mismatch sends the block idle until the next `standbyIn` pulse.
- R4: Command byte 0x96 with `byteMak` = 0 sets `welOut`. It also raises `sakReq` for exactly one cycle. Both outputs change on the clock edge that accepts the byte.
- R5: Command byte 0x91 with `byteMak` = 0 clears `welOut` and raises `sakReq` for one cycle on the accepting edge.
- R6: Command byte 0x96 or 0x91 with `byteMak` = 1 raises no `sakReq`, leaves `welOut` unchanged and sends the block idle.
- R7: Any other command byte pulses `cmdValid` for one cycle on the accepting edge, with `cmdByte` and `cmdMak` holding the byte and its flag. `welOut` does not change and `sakReq` does not rise.
- R8: A pulse on `doneWrite`, `doneWrsr`, `doneEral` or `doneSetal` clears `welOut` on that clock edge. If it coincides with an accepted 0x96, the clear wins, though `sakReq` still pulses.
- R9: A `standbyIn` pulse restarts header checking from any phase and abandons a partly received transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| standbyIn | input | 1 | One-cycle standby-gap marker |
| byteValid | input | 1 | A received byte is presented this cycle |
| byteData | input | 8 | Received byte |
| byteMak | input | 1 | 1 = master acknowledged the byte, 0 = not-acknowledge |
| altAddrSel | input | 1 | Address LSB must be 1 |
| doneWrite | input | 1 | Array write completed |
| doneWrsr | input | 1 | Status-register write completed |
| doneEral | input | 1 | Erase-all completed |
| doneSetal | input | 1 | Set-all completed |
| welOut | output | 1 | Write-enable latch |
| sakReq | output | 1 | Request to send a slave acknowledge |
| cmdValid | output | 1 | Unowned command handed downstream |
| cmdByte | output | 8 | Command byte handed downstream |
| cmdMak | output | 1 | Acknowledge flag of that command byte |

## Verification
Every output is registered once after the decode. Each result of a byte or strobe applied before edge N is therefore visible right after edge N. The driver applies inputs on the falling edge and queues the expected outputs for the next rising edge. The monitor pops that entry 2 ns after the rising edge, so each comparison lines up with exactly one stimulus cycle. Idle cycles after a command check that pulses last only one cycle and that the latch holds.

// File: rtl/swire_wel_pkg.sv
package swire_wel_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HDR,
    PH_ADDR,
    PH_CMD
  } phase_t;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic passCmd;
  } ctlStrobe_t;
endpackage

// File: rtl/swire_wel_ctl.sv
module swire_wel_ctl
  import swire_wel_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] HDR_CODE = 8'h55,
  parameter logic [DATA_W-1:0] DEV_ADDR = 8'hA0,
  parameter logic [DATA_W-1:0] CMD_SET  = 8'h96,
  parameter logic [DATA_W-1:0] CMD_CLR  = 8'h91
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              standbyIn,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              byteMak,
  input  logic              altAddrSel,
  output ctlStrobe_t        strobe
);
  phase_t phase, phaseNext;
  logic [DATA_W-1:0] expAddr;

  assign expAddr = {DEV_ADDR[DATA_W-1:1], DEV_ADDR[0] | altAddrSel};

  always_comb begin
    phaseNext = phase;
    strobe    = '0;
    if (standbyIn) begin
      phaseNext = PH_HDR;
    end else if (byteValid) begin
      unique case (phase)
        PH_IDLE: phaseNext = PH_IDLE;
        PH_HDR:  phaseNext = (byteData == HDR_CODE) ? PH_ADDR : PH_IDLE;
        PH_ADDR: phaseNext = (byteData == expAddr) ? PH_CMD : PH_IDLE;
        PH_CMD: begin
          phaseNext = PH_IDLE;
          if (byteData == CMD_SET)      strobe.setWel  = !byteMak;
          else if (byteData == CMD_CLR) strobe.clrWel  = !byteMak;
          else                          strobe.passCmd = 1'b1;
        end
        default: phaseNext = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setWel, strobe.clrWel, strobe.passCmd}));

  // R6
  cmd_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CMD && byteValid && !standbyIn) |=> (phase == PH_IDLE));

  // R9
  standby_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    standbyIn |=> (phase == PH_HDR));
endmodule

// File: rtl/swire_wel_dp.sv
module swire_wel_dp
  import swire_wel_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_DONE = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [DATA_W-1:0]   byteData,
  input  logic                byteMak,
  input  logic [NUM_DONE-1:0] doneVec,
  output logic                welOut,
  output logic                sakReq,
  output logic                cmdValid,
  output logic [DATA_W-1:0]   cmdByte,
  output logic                cmdMak
);
  logic anyDone;
  assign anyDone = |doneVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      welOut   <= 1'b0;
      sakReq   <= 1'b0;
      cmdValid <= 1'b0;
      cmdByte  <= '0;
      cmdMak   <= 1'b0;
    end else begin
      sakReq   <= strobe.setWel | strobe.clrWel;
      cmdValid <= strobe.passCmd;
      if (strobe.passCmd) begin
        cmdByte <= byteData;
        cmdMak  <= byteMak;
      end
      if (anyDone || strobe.clrWel) welOut <= 1'b0;
      else if (strobe.setWel)       welOut <= 1'b1;
    end
  end

  // R8
  done_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyDone |=> !welOut);

  // R4
  sak_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sakReq |=> !sakReq);

  // R4
  rise_needs_sak_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(welOut) |-> sakReq);

  // R7
  sak_cmd_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sakReq && cmdValid));
endmodule

// File: rtl/swire_wel_ctrl.sv
module swire_wel_ctrl
  import swire_wel_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              standbyIn,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              byteMak,
  input  logic              altAddrSel,
  input  logic              doneWrite,
  input  logic              doneWrsr,
  input  logic              doneEral,
  input  logic              doneSetal,
  output logic              welOut,
  output logic              sakReq,
  output logic              cmdValid,
  output logic [DATA_W-1:0] cmdByte,
  output logic              cmdMak
);
  localparam int NUM_DONE = 4;

  ctlStrobe_t strobe;
  logic [NUM_DONE-1:0] doneVec;

  assign doneVec = {doneSetal, doneEral, doneWrsr, doneWrite};

  swire_wel_ctl #(.DATA_W(DATA_W)) i_ctl (
    .clk(clk), .rstN(rstN), .standbyIn(standbyIn), .byteValid(byteValid),
    .byteData(byteData), .byteMak(byteMak), .altAddrSel(altAddrSel),
    .strobe(strobe)
  );

  swire_wel_dp #(.DATA_W(DATA_W), .NUM_DONE(NUM_DONE)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .byteData(byteData),
    .byteMak(byteMak), .doneVec(doneVec), .welOut(welOut), .sakReq(sakReq),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .cmdMak(cmdMak)
  );
endmodule

// File: tb/test_swire_wel_ctrl.sv
module test_swire_wel_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic standbyIn = 0, byteValid = 0, byteMak = 0, altAddrSel = 0;
  logic [7:0] byteData = '0;
  logic doneWrite = 0, doneWrsr = 0, doneEral = 0, doneSetal = 0;
  logic welOut, sakReq, cmdValid, cmdMak;
  logic [7:0] cmdByte;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic sak; logic cv; logic [7:0] cb; logic cm; logic lat; string tag;
  } exp_t;
  exp_t expQ[$];

  always #4 clk = ~clk;

  swire_wel_ctrl i_swire_wel_ctrl (
    .clk(clk), .rstN(rstN), .standbyIn(standbyIn), .byteValid(byteValid),
    .byteData(byteData), .byteMak(byteMak), .altAddrSel(altAddrSel),
    .doneWrite(doneWrite), .doneWrsr(doneWrsr), .doneEral(doneEral),
    .doneSetal(doneSetal), .welOut(welOut), .sakReq(sakReq),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .cmdMak(cmdMak)
  );

  // monitor: compares the result of the cycle driven before this edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (sakReq !== e.sak || cmdValid !== e.cv || welOut !== e.lat ||
          (e.cv && (cmdByte !== e.cb || cmdMak !== e.cm))) begin
        fails++;
        $display("FAIL %s: got sak=%b cv=%b cb=%h cm=%b wel=%b, expected sak=%b cv=%b cb=%h cm=%b wel=%b",
                 e.tag, sakReq, cmdValid, cmdByte, cmdMak, welOut,
                 e.sak, e.cv, e.cb, e.cm, e.lat);
      end
    end
  end

  task automatic drive(input logic sb, input logic bv, input logic [7:0] d,
                       input logic mak, input logic [3:0] done,
                       input logic eSak, input logic eCv, input logic eLat,
                       input string tag);
    exp_t e;
    @(negedge clk);
    standbyIn = sb; byteValid = bv; byteData = d; byteMak = mak;
    {doneSetal, doneEral, doneWrsr, doneWrite} = done;
    e.sak = eSak; e.cv = eCv; e.cb = d; e.cm = mak; e.lat = eLat; e.tag = tag;
    expQ.push_back(e);
    @(posedge clk);
  endtask

  task automatic idle(input logic lat, input string tag);
    drive(0, 0, 8'h00, 0, 4'b0, 0, 0, lat, tag);
  endtask

  // standby, header, address; outputs stay quiet and latch holds
  task automatic preamble(input logic [7:0] addr, input logic lat, input string tag);
    drive(1, 0, 8'h00, 0, 4'b0, 0, 0, lat, tag);
    drive(0, 1, 8'h55, 1, 4'b0, 0, 0, lat, tag);
    drive(0, 1, addr,  1, 4'b0, 0, 0, lat, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (welOut !== 0 || sakReq !== 0 || cmdValid !== 0) begin
      fails++;
      $display("FAIL R1: got wel=%b sak=%b cv=%b, expected 0 0 0", welOut, sakReq, cmdValid);
    end
    rstN = 1'b1;
    idle(0, "R1 first cycle");

    // R4 enable
    preamble(8'hA0, 0, "R4 preamble");
    drive(0, 1, 8'h96, 0, 4'b0, 1, 0, 1, "R4 enable");
    idle(1, "R4 pulse width");
    // R5 disable
    preamble(8'hA0, 1, "R5 preamble");
    drive(0, 1, 8'h91, 0, 4'b0, 1, 0, 0, "R5 disable");
    idle(0, "R5 pulse width");

    // R6 enable closed with acknowledge, then stray byte without standby
    preamble(8'hA0, 0, "R6 preamble");
    drive(0, 1, 8'h96, 1, 4'b0, 0, 0, 0, "R6 enable acked");
    drive(0, 1, 8'h96, 0, 4'b0, 0, 0, 0, "R6 idle after invalid");
    preamble(8'hA0, 0, "R6 preamble2");
    drive(0, 1, 8'h96, 0, 4'b0, 1, 0, 1, "R6 set before");
    preamble(8'hA0, 1, "R6 preamble3");
    drive(0, 1, 8'h91, 1, 4'b0, 0, 0, 1, "R6 disable acked");

    // R3 address checks
    preamble(8'hA1, 1, "R3 wrong addr");
    drive(0, 1, 8'h91, 0, 4'b0, 0, 0, 1, "R3 ignored after mismatch");
    altAddrSel = 1;
    preamble(8'hA0, 1, "R3 alt rejects A0");
    drive(0, 1, 8'h91, 0, 4'b0, 0, 0, 1, "R3 alt ignored");
    preamble(8'hA1, 1, "R3 alt accepts A1");
    drive(0, 1, 8'h91, 0, 4'b0, 1, 0, 0, "R3 alt disable");
    altAddrSel = 0;

    // R2 bad header
    drive(1, 0, 8'h00, 0, 4'b0, 0, 0, 0, "R2 standby");
    drive(0, 1, 8'h54, 0, 4'b0, 0, 0, 0, "R2 bad header");
    drive(0, 1, 8'hA0, 0, 4'b0, 0, 0, 0, "R2 addr ignored");
    drive(0, 1, 8'h96, 0, 4'b0, 0, 0, 0, "R2 cmd ignored");

    // R7 unknown command
    preamble(8'hA0, 0, "R7 preamble");
    drive(0, 1, 8'h03, 1, 4'b0, 0, 1, 0, "R7 pass through");
    idle(0, "R7 pulse width");
    preamble(8'hA0, 0, "R7 preamble2");
    drive(0, 1, 8'h96, 0, 4'b0, 1, 0, 1, "R7 set");
    preamble(8'hA0, 1, "R7 preamble3");
    drive(0, 1, 8'h05, 0, 4'b0, 0, 1, 1, "R7 latch kept");

    // R8 each completion strobe clears
    for (int i = 0; i < 4; i++) begin
      logic [3:0] d;
      d = 4'b0001 << i;
      preamble(8'hA0, (i == 0) ? 1'b1 : 1'b0, "R8 preamble");
      drive(0, 1, 8'h96, 0, 4'b0, 1, 0, 1, "R8 set");
      drive(0, 0, 8'h00, 0, d, 0, 0, 0, "R8 strobe clears");
    end
    preamble(8'hA0, 0, "R8 preamble clash");
    drive(0, 1, 8'h96, 0, 4'b0010, 1, 0, 0, "R8 clear wins");

    // R9 restart mid-transaction
    drive(1, 0, 8'h00, 0, 4'b0, 0, 0, 0, "R9 standby");
    drive(0, 1, 8'h55, 1, 4'b0, 0, 0, 0, "R9 header");
    preamble(8'hA0, 0, "R9 restart");
    drive(0, 1, 8'h96, 0, 4'b0, 1, 0, 1, "R9 enable after restart");
    idle(1, "R9 hold");

    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule